// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block is a clocked static memory with a 15-bit word address and a 32-bit word split into four byte lanes. An access starts on a clock edge where one of two address strobes is accepted. The host strobe is honoured only while the primary select is low. The control strobe is always honoured and may write on the very edge that starts it. Once an access is open, the block owns a two-bit beat counter. Each later edge either holds the beat or, when the step input is low, moves to the next beat. That edge then reads or writes the word at the resulting burst address. The order of the four beats is either linear, wrapping inside the aligned group of four, or interleaved, where the low address bits are XORed with the beat number. The order-select input is meant to stay fixed during operation.

Reads are pipelined. The word addressed on a read edge appears after the following edge. The output enable gates it without waiting for a clock. The data path is modelled as a data bus plus a drive flag: when the flag is low, the bus reads as zero and stands for high impedance. Storage holds 2^STORE_AW words, 512 by default. Address bits above that range are folded onto the stored words. Every strobe, select and write control is active low, except the active-high secondary select.

Top module: `sync_burst_ram`

## Requirements
- R1: After reset no access is open. Edges without an accepted strobe neither drive the output nor write, even with the step input low.
- R2: An edge with the control strobe low (host strobe not accepted) opens an access if sel_n=0, sel_hi=1 and sel2_n=0. On that same edge the write controls and din are sampled and the write is made to the strobed address.
- R3: A low host strobe while sel_n is high is ignored. An open burst keeps its start address and beat sequence.
- R4: sel_hi and sel2_n are sampled only on edges where a strobe is accepted. Changing them on other edges does not close an open access.
- R5: The edge that accepts the host strobe performs no write, only a read. A later edge with step_n high and write controls asserted writes the start address.
- R6: On a non-strobe edge of an open access, step_n=0 advances the beat by one (modulo 4) before the access is made, and step_n=1 keeps the beat.
- R7: With order_lin=1 the low two address bits are (start + beat) mod 4. With order_lin=0 they are start XOR beat. The upper bits stay those of the start address.
- R8: all_wr_n=0 writes all four lanes. Otherwise, lane_wr_en_n=0 writes each lane i whose lane_n[i] is 0 (lane i is din bits 8i+7..8i). Otherwise nothing is written.
- R9: For a read access on edge E, dout holds the addressed word after edge E+1, and dout_drv is 1 while out_en_n is 0.
- R10: out_en_n=1 forces dout_drv low at once, without a clock edge.
- R11: After a write on edge E, dout_drv is 0 after edge E+1.
- R12: An accepted strobe with a select condition false closes the access. Later edges without a new start neither write nor drive the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 15 | Word address, sampled on strobe edges |
| din | input | 32 | Write data |
| host_strb_n | input | 1 | Host address strobe, masked by sel_n |
| ctl_strb_n | input | 1 | Control address strobe, can write on its own edge |
| step_n | input | 1 | Burst step request |
| sel_n | input | 1 | Primary select, active low |
| sel_hi | input | 1 | Secondary select, active high |
| sel2_n | input | 1 | Secondary select, active low |
| all_wr_n | input | 1 | Write all four lanes |
| lane_wr_en_n | input | 1 | Enables the per-lane strobes |
| lane_n | input | 4 | Per-lane write strobes |
| order_lin | input | 1 | Burst order: 1 linear, 0 interleaved |
| out_en_n | input | 1 | Output enable, asynchronous |
| dout | output | 32 | Read data, zero when not driven |
| dout_drv | output | 1 | Output drive flag (0 = high impedance) |

## Verification
A wrong beat count or wrong burst order shows up as the wrong word on dout exactly one edge after the faulty read edge, so burst reads are checked beat by beat at that point. A stale open flag or start address shows up either as a drive flag that stays high after a deselect, or as a write that should have been dropped. The dropped write is caught by the next read of that word, two edges later. Byte-lane faults appear only in the merged word, so lane writes are always read back against a word preloaded with distinct bytes.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int BEAT_W = 2;

  function automatic logic [BEAT_W-1:0] beat_low(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] beat,
    input logic              linear
  );
    logic [BEAT_W-1:0] r;
    if (linear) r = start + beat;
    else        r = start ^ beat;
    return r;
  endfunction
endpackage

// File: rtl/sbs_beat_ctr.sv
module sbs_beat_ctr
  import sbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              inc,
  output logic [BEAT_W-1:0] cnt_q
);
  logic [BEAT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + BEAT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R6: a step moves the beat by exactly one
  a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr) |=> (cnt_q == $past(cnt_q) + BEAT_W'(1)));
  // R6: no step, no start: beat holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/sbs_access_ctl.sv
module sbs_access_ctl
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              host_strb_n,
  input  logic              ctl_strb_n,
  input  logic              step_n,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              sel2_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_en_n,
  input  logic [LANES-1:0]  lane_n,
  input  logic              order_lin,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [LANES-1:0]  wr_mask,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] rd_addr_q,
  output logic              rd_pend_q
);
  logic              host_go, ctl_go, strobe, chip_ok, start, cont, adv, rd_now;
  logic              active_q, active_d;
  logic [ADDR_W-1:0] base_q, base_d, rd_addr_d;
  logic [BEAT_W-1:0] cnt_q, beat_eff;
  logic [LANES-1:0]  lane_req;

  // strobe decode: host strobe masked by primary select and wins a tie
  always_comb begin
    host_go  = !host_strb_n && !sel_n;
    ctl_go   = !ctl_strb_n && !host_go;
    strobe   = host_go || ctl_go;
    chip_ok  = !sel_n && sel_hi && !sel2_n;
    start    = strobe && chip_ok;
    cont     = !strobe && active_q;
    adv      = cont && !step_n;
  end

  sbs_beat_ctr u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (strobe),
    .inc   (adv),
    .cnt_q (cnt_q)
  );

  // address and write mask for this edge
  always_comb begin
    beat_eff = adv ? cnt_q + BEAT_W'(1) : cnt_q;
    if (start)
      acc_addr = addr;
    else
      acc_addr = {base_q[ADDR_W-1:BEAT_W], beat_low(base_q[BEAT_W-1:0], beat_eff, order_lin)};

    if (!all_wr_n)          lane_req = '1;
    else if (!lane_wr_en_n) lane_req = ~lane_n;
    else                    lane_req = '0;

    wr_mask = ((start && ctl_go) || cont) ? lane_req : '0;
    wr_fire = |wr_mask;
    rd_now  = (start || cont) && !wr_fire;
  end

  // next state
  always_comb begin
    active_d  = strobe ? chip_ok : active_q;
    base_d    = start ? addr : base_q;
    rd_addr_d = rd_now ? acc_addr : rd_addr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      base_q    <= '0;
      rd_addr_q <= '0;
      rd_pend_q <= 1'b0;
    end else begin
      active_q  <= active_d;
      base_q    <= base_d;
      rd_addr_q <= rd_addr_d;
      rd_pend_q <= rd_now;
    end
  end

  // R3: a masked host strobe changes neither the start address nor the open flag
  a_r3_masked_host: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_strb_n && sel_n && ctl_strb_n) |=> ($stable(base_q) && $stable(active_q)));
  // R4: without any strobe the secondary selects cannot close or open an access
  a_r4_no_strobe_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
    (host_strb_n && ctl_strb_n) |=> $stable(active_q));
  // R12: nothing is written while closed and not starting
  a_r12_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !start) |-> !wr_fire);
endmodule

// File: rtl/sbs_lane_ram.sv
module sbs_lane_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/sync_burst_ram.sv
module sync_burst_ram
  import sbs_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 32,
  parameter int STORE_AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              host_strb_n,
  input  logic              ctl_strb_n,
  input  logic              step_n,
  input  logic              sel_n,
  input  logic              sel_hi,
  input  logic              sel2_n,
  input  logic              all_wr_n,
  input  logic              lane_wr_en_n,
  input  logic [DATA_W/8-1:0] lane_n,
  input  logic              order_lin,
  input  logic              out_en_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_drv
);
  localparam int LANES = DATA_W / 8;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [ADDR_W-1:0] acc_addr, rd_addr_q;
  logic [LANES-1:0]  wr_mask;
  logic              wr_fire, rd_pend_q;

  sbs_access_ctl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .addr         (addr),
    .host_strb_n  (host_strb_n),
    .ctl_strb_n   (ctl_strb_n),
    .step_n       (step_n),
    .sel_n        (sel_n),
    .sel_hi       (sel_hi),
    .sel2_n       (sel2_n),
    .all_wr_n     (all_wr_n),
    .lane_wr_en_n (lane_wr_en_n),
    .lane_n       (lane_n),
    .order_lin    (order_lin),
    .acc_addr     (acc_addr),
    .wr_mask      (wr_mask),
    .wr_fire      (wr_fire),
    .rd_addr_q    (rd_addr_q),
    .rd_pend_q    (rd_pend_q)
  );

  // fold address bits beyond the stored range onto the word index
  logic [STORE_AW-1:0] wr_idx, rd_idx;
  always_comb begin
    wr_idx = acc_addr[STORE_AW-1:0];
    rd_idx = rd_addr_q[STORE_AW-1:0];
    for (int i = STORE_AW; i < ADDR_W; i++) begin
      wr_idx[(i - STORE_AW) % STORE_AW] ^= acc_addr[i];
      rd_idx[(i - STORE_AW) % STORE_AW] ^= rd_addr_q[i];
    end
  end

  logic [DATA_W-1:0] rd_word;
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbs_lane_ram #(.AW(STORE_AW), .DW(8)) u_lane (
      .clk   (clk),
      .we    (wr_mask[g]),
      .waddr (wr_idx),
      .wdata (din[8*g +: 8]),
      .raddr (rd_idx),
      .rdata (rd_word[8*g +: 8])
    );
  end

  // output stage
  logic              rd_valid_q;
  logic [DATA_W-1:0] dout_q;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_valid_q <= 1'b0;
      dout_q     <= '0;
    end else begin
      rd_valid_q <= rd_pend_q;
      if (rd_pend_q) dout_q <= rd_word;
    end
  end

  assign dout_drv = rd_valid_q && !out_en_n;
  assign dout     = dout_drv ? dout_q : '0;

  // R11: two edges after a write edge nothing drives the bus
  a_r11_write_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_fire |=> ##1 !rd_valid_q);
endmodule

// File: tb/sync_burst_ram_test.sv
module sync_burst_ram_test;
  logic        clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [14:0] addr;
  logic [31:0] din;
  logic        host_strb_n, ctl_strb_n, step_n, sel_n, sel_hi, sel2_n;
  logic        all_wr_n, lane_wr_en_n, order_lin, out_en_n;
  logic [3:0]  lane_n;
  logic [31:0] dout;
  logic        dout_drv;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [512];

  localparam logic [31:0] W0 = 32'hA0A0_0001, W1 = 32'hB1B1_0002,
                          W2 = 32'hC2C2_0003, W3 = 32'hD3D3_0004;

  sync_burst_ram uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .host_strb_n(host_strb_n), .ctl_strb_n(ctl_strb_n), .step_n(step_n),
    .sel_n(sel_n), .sel_hi(sel_hi), .sel2_n(sel2_n),
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n), .lane_n(lane_n),
    .order_lin(order_lin), .out_en_n(out_en_n), .dout(dout), .dout_drv(dout_drv)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    host_strb_n = 1'b1; ctl_strb_n = 1'b1; step_n = 1'b1;
    all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_n = 4'hF;
    sel_n = 1'b0; sel_hi = 1'b1; sel2_n = 1'b0;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctl_wr(logic [14:0] a, logic [31:0] d);
    ctl_strb_n = 1'b0; addr = a; din = d; all_wr_n = 1'b0;
    tick();
    model[a[8:0]] = d;
    idle();
  endtask

  task automatic host_start(logic [14:0] a);
    host_strb_n = 1'b0; addr = a;
    tick();
    idle();
  endtask

  task automatic rd_chk(logic [14:0] a, string tag);
    host_start(a);
    tick();
    chk({tag, " drive"}, 32'(dout_drv), 32'd1);
    chk(tag, dout, model[a[8:0]]);
  endtask

  task automatic t_reset();
    chk("R1 reset drive", 32'(dout_drv), 32'd0);
    step_n = 1'b0; all_wr_n = 1'b0; din = 32'hFFFF_FFFF;
    repeat (3) tick();
    chk("R1 no access before start", 32'(dout_drv), 32'd0);
    idle();
  endtask

  task automatic t_ctl_write();
    ctl_wr(15'd5, 32'h1122_3344);
    tick();
    chk("R11 quiet after write", 32'(dout_drv), 32'd0);
    rd_chk(15'd5, "R2 R9 same-edge write read back");
    ctl_wr(15'd0, 32'h0);
    rd_chk(15'd0, "R1 write after reset landed");
  endtask

  task automatic t_host_bytes();
    ctl_wr(15'd9, 32'hAABB_CCDD);
    ctl_wr(15'd12, 32'h0C0C_0C0C);
    host_start(15'd9);
    lane_wr_en_n = 1'b0; lane_n = 4'b1010; din = 32'h1122_3344;
    tick();
    model[9] = 32'hAA22_CC44;
    idle();
    rd_chk(15'd9, "R8 R5 lane merge");
    host_start(15'd9);
    lane_n = 4'h0; din = 32'hFFFF_FFFF;
    tick();
    idle();
    rd_chk(15'd9, "R8 lanes without enable");
    host_start(15'd9);
    all_wr_n = 1'b0; lane_wr_en_n = 1'b0; lane_n = 4'hE; din = 32'h5566_7788;
    tick();
    model[9] = 32'h5566_7788;
    idle();
    rd_chk(15'd9, "R8 global override");
    host_strb_n = 1'b0; addr = 15'd12; all_wr_n = 1'b0; din = 32'hDEAD_BEEF;
    tick();
    idle();
    tick();
    chk("R5 no write on host start", dout, 32'h0C0C_0C0C);
  endtask

  task automatic t_burst_write();
    order_lin = 1'b1;
    ctl_strb_n = 1'b0; addr = 15'h22; all_wr_n = 1'b0; din = W0;
    tick();
    ctl_strb_n = 1'b1; step_n = 1'b0;
    din = W1; tick();
    din = W2; tick();
    din = W3; tick();
    idle();
    model[9'h22] = W0; model[9'h23] = W1; model[9'h20] = W2; model[9'h21] = W3;
    rd_chk(15'h20, "R7 linear beat2");
    rd_chk(15'h21, "R7 linear beat3");
    rd_chk(15'h22, "R7 linear beat0");
    rd_chk(15'h23, "R7 linear beat1");
  endtask

  task automatic t_interleave();
    order_lin = 1'b0;
    host_start(15'h21);
    step_n = 1'b0;
    tick(); chk("R7 interleave first", dout, W3);
    tick(); chk("R7 interleave second", dout, W2);
    tick(); chk("R7 interleave third", dout, W1);
    step_n = 1'b1;
    tick(); chk("R7 interleave fourth", dout, W0);
    order_lin = 1'b1;
  endtask

  task automatic t_stall();
    host_start(15'h20);
    step_n = 1'b0; tick(); chk("R6 step first", dout, W2);
    step_n = 1'b1; tick(); chk("R6 step second", dout, W3);
    step_n = 1'b0; tick(); chk("R6 hold repeats", dout, W3);
    idle();        tick(); chk("R6 step after hold", dout, W0);
  endtask

  task automatic t_blocked();
    host_start(15'h20);
    host_strb_n = 1'b0; sel_n = 1'b1; addr = 15'd5; step_n = 1'b0;
    tick();
    chk("R3 burst continues", dout, W2);
    idle();
    tick();
    chk("R3 masked strobe ignored", dout, W3);
  endtask

  task automatic t_secondary();
    host_start(15'd9);
    sel_hi = 1'b0; sel2_n = 1'b1;
    tick();
    chk("R4 read despite secondary", dout, model[9]);
    tick();
    chk("R4 still open", 32'(dout_drv), 32'd1);
    idle();
  endtask

  task automatic t_deselect();
    host_strb_n = 1'b0; sel2_n = 1'b1; addr = 15'd9;
    tick();
    idle();
    tick();
    chk("R12 closed drive", 32'(dout_drv), 32'd0);
    all_wr_n = 1'b0; din = 32'h0;
    tick();
    idle();
    tick();
    chk("R12 closed write no drive", 32'(dout_drv), 32'd0);
    rd_chk(15'd9, "R12 write ignored while closed");
    ctl_strb_n = 1'b0; sel_n = 1'b1;
    tick();
    idle();
    tick();
    chk("R12 control strobe deselect", 32'(dout_drv), 32'd0);
  endtask

  task automatic t_oe();
    rd_chk(15'd5, "R9 plain read");
    out_en_n = 1'b1;
    #1;
    chk("R10 output disabled", 32'(dout_drv), 32'd0);
    out_en_n = 1'b0;
    #1;
    chk("R10 output re-enabled", 32'(dout_drv), 32'd1);
    chk("R10 data kept", dout, model[5]);
  endtask

  initial begin
    idle();
    order_lin = 1'b1; out_en_n = 1'b0; addr = '0; din = '0;
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    t_reset();
    t_ctl_write();
    t_host_bytes();
    t_burst_write();
    t_interleave();
    t_stall();
    t_blocked();
    t_secondary();
    t_deselect();
    t_oe();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule